// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block works out where the program counter goes when the core takes a fault or an interrupt, and where it goes when the return-from-exception instruction executes. Bit 0 of a PC marks privileged mode. On an entry, it forms a new PC from the privileged base register plus a per-code vector offset. It also produces the following PC and decides whether, and with what value, the exception-address register is written. On a return, it checks that the core is in privileged mode and steers execution back to the saved exception address.

The block also tracks whether the banked shadow registers are in use. Entry from non-privileged mode asks for a swap into the shadow state. A return to a saved address with bit 0 clear asks for a swap back out. A swap request toward the state that is already in effect is flagged as an error and is not issued. Each strobe takes effect in one cycle: all outputs are registered and valid on the clock edge after the strobe.

Top module: `trap_sequencer`

## Requirements
- R1: During and directly after reset, redirValid, excAddrWe, swapReq, swapDir, illegalRet and swapErr are 0, newPc, nextPc and excAddrVal are 0, and shadowActive is 0.
- R2: One cycle after faultValid, redirValid is 1, newPc equals privBase plus the vector offset for faultCode, and nextPc equals commitPc + 4. The default offset for code k is 256*(k+1).
- R3: One cycle after an entry, excAddrWe is 1 and excAddrVal is based on commitPc. The one exception is code 1 (interrupt) with commitPc bit 0 set, where excAddrWe is 0.
- R4: For code 2 (privileged call) and code 3 (arithmetic), the written excAddrVal is commitPc + 4. For every other code it is commitPc.
- R5: An entry with commitPc bit 0 clear, while shadowActive is 0, gives swapReq=1 and swapDir=1 one cycle later, and sets shadowActive.
- R6: retValid without faultValid while commitPc bit 0 is 0 gives illegalRet=1 one cycle later, with redirValid, excAddrWe and swapReq all 0.
- R7: retValid without faultValid while commitPc bit 0 is 1 gives redirValid=1, nextPc=savedExcAddr, newPc=commitPc+4 and excAddrWe=0 one cycle later.
- R8: On a valid return with savedExcAddr bit 0 clear while shadowActive is 1, swapReq=1 and swapDir=0 one cycle later, and shadowActive clears. With savedExcAddr bit 0 set, no swap is requested.
- R9: A swap requested toward the state already in effect (swap in while shadowActive=1, or swap out while shadowActive=0) gives swapErr=1 and swapReq=0, and shadowActive keeps its value.
- R10: When faultValid and retValid are asserted together, the entry behaviour applies, and the return has no effect (illegalRet stays 0).
- R11: In a cycle with neither strobe, the next cycle shows redirValid, excAddrWe, swapReq, illegalRet and swapErr all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| commitPc | input | PC_W | PC of the instruction at commit; bit 0 marks privileged mode |
| faultCode | input | 4 | Code of the fault or interrupt being taken |
| faultValid | input | 1 | Entry strobe |
| retValid | input | 1 | Return-from-exception strobe |
| privBase | input | PC_W | Privileged-mode base address |
| savedExcAddr | input | PC_W | Current exception-address register value |
| redirValid | output | 1 | newPc/nextPc carry a redirect this cycle |
| newPc | output | PC_W | Redirect PC |
| nextPc | output | PC_W | PC following the redirect |
| excAddrWe | output | 1 | Write strobe for the exception-address register |
| excAddrVal | output | PC_W | Value to write into the exception-address register |
| swapReq | output | 1 | Shadow-register swap request |
| swapDir | output | 1 | Swap direction: 1 into shadow, 0 out |
| illegalRet | output | 1 | Return attempted outside privileged mode |
| swapErr | output | 1 | Swap requested toward the state already in effect |
| shadowActive | output | 1 | Shadow registers currently in use |

## Verification
The bench builds the block with PC_W = 16 and the default offset table. This keeps every PC value in a form where a wrong carry, a wrong offset or a lost bit 0 shows up directly. The sweep covers all 16 fault codes, both privilege settings of commitPc and both settings of bit 0 of the saved address. It also takes the sequence through both shadow states, so that swap-in, swap-out and both error directions follow one another. Simultaneous strobes and idle cycles are mixed in, so that the entry priority and the quiet outputs are checked against a running model of the shadow state.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int OFS_W     = 16;
  localparam int OFS_STEP  = 256;

  localparam logic [CODE_W-1:0] CODE_INTR  = CODE_W'(1);
  localparam logic [CODE_W-1:0] CODE_CALL  = CODE_W'(2);
  localparam logic [CODE_W-1:0] CODE_ARITH = CODE_W'(3);

  typedef logic [OFS_W-1:0] vec_table_t [NUM_CODES];

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic entry;         // fault/interrupt taken
    logic ret;           // legal return
    logic badRet;        // return outside privileged mode
    logic writeRestart;  // exception address gets written
    logic skipInsn;      // restart after the faulting instruction
    logic swapIn;
    logic swapOut;
    logic swapErr;
  } seq_ctl_t;

  function automatic vec_table_t defaultVecTable();
    vec_table_t t;
    for (int k = 0; k < NUM_CODES; k++) begin
      t[k] = OFS_W'((k + 1) * OFS_STEP);
    end
    return t;
  endfunction

endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic              retValid,
  input  logic [CODE_W-1:0] faultCode,
  input  logic              commitPriv,
  input  logic              savedUsr,
  output seq_ctl_t          ctl,
  output logic              redirValid,
  output logic              excAddrWe,
  output logic              swapReq,
  output logic              swapDir,
  output logic              illegalRet,
  output logic              swapErr,
  output logic              shadowActive
);

  logic isEntry;
  logic isRet;
  logic wantIn;
  logic wantOut;

  always_comb begin
    // Entry wins over a simultaneous return.
    isEntry = faultValid;
    isRet   = retValid && !faultValid;

    ctl.entry        = isEntry;
    ctl.ret          = isRet && commitPriv;
    ctl.badRet       = isRet && !commitPriv;
    ctl.writeRestart = isEntry && !((faultCode == CODE_INTR) && commitPriv);
    ctl.skipInsn     = (faultCode == CODE_CALL) || (faultCode == CODE_ARITH);

    wantIn  = isEntry && !commitPriv;
    wantOut = ctl.ret && savedUsr;

    ctl.swapIn  = wantIn && !shadowActive;
    ctl.swapOut = wantOut && shadowActive;
    ctl.swapErr = (wantIn && shadowActive) || (wantOut && !shadowActive);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirValid   <= 1'b0;
      excAddrWe    <= 1'b0;
      swapReq      <= 1'b0;
      swapDir      <= 1'b0;
      illegalRet   <= 1'b0;
      swapErr      <= 1'b0;
      shadowActive <= 1'b0;
    end else begin
      redirValid <= ctl.entry || ctl.ret;
      excAddrWe  <= ctl.writeRestart;
      illegalRet <= ctl.badRet;
      swapErr    <= ctl.swapErr;
      swapReq    <= ctl.swapIn || ctl.swapOut;
      if (ctl.swapIn) begin
        swapDir      <= 1'b1;
        shadowActive <= 1'b1;
      end else if (ctl.swapOut) begin
        swapDir      <= 1'b0;
        shadowActive <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/trap_seq_dp.sv
module trap_seq_dp
  import trap_seq_pkg::*;
#(
  parameter int         PC_W    = 32,
  parameter vec_table_t VEC_OFS = defaultVecTable()
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic [PC_W-1:0]   commitPc,
  input  logic [CODE_W-1:0] faultCode,
  input  logic [PC_W-1:0]   privBase,
  input  logic [PC_W-1:0]   savedExcAddr,
  output logic [PC_W-1:0]   newPc,
  output logic [PC_W-1:0]   nextPc,
  output logic [PC_W-1:0]   excAddrVal
);

  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  logic [OFS_W-1:0] ofsTerm [NUM_CODES];
  logic [OFS_W-1:0] ofsSel;
  logic [PC_W-1:0]  pcPlus;
  logic [PC_W-1:0]  vecPc;
  logic [PC_W-1:0]  restartPc;

  // One-hot select of the vector offset, one term per code.
  for (genvar k = 0; k < NUM_CODES; k++) begin : g_ofs
    assign ofsTerm[k] = (faultCode == CODE_W'(k)) ? VEC_OFS[k] : '0;
  end

  always_comb begin
    ofsSel = '0;
    for (int k = 0; k < NUM_CODES; k++) begin
      ofsSel = ofsSel | ofsTerm[k];
    end
    pcPlus    = commitPc + INSN_BYTES;
    vecPc     = privBase + PC_W'(ofsSel);
    restartPc = ctl.skipInsn ? pcPlus : commitPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newPc      <= '0;
      nextPc     <= '0;
      excAddrVal <= '0;
    end else begin
      if (ctl.entry) begin
        newPc  <= vecPc;
        nextPc <= pcPlus;
      end else if (ctl.ret) begin
        newPc  <= pcPlus;
        nextPc <= savedExcAddr;
      end
      if (ctl.writeRestart) begin
        excAddrVal <= restartPc;
      end
    end
  end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_seq_pkg::*;
#(
  parameter int         PC_W    = 32,
  parameter vec_table_t VEC_OFS = defaultVecTable()
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   commitPc,
  input  logic [CODE_W-1:0] faultCode,
  input  logic              faultValid,
  input  logic              retValid,
  input  logic [PC_W-1:0]   privBase,
  input  logic [PC_W-1:0]   savedExcAddr,
  output logic              redirValid,
  output logic [PC_W-1:0]   newPc,
  output logic [PC_W-1:0]   nextPc,
  output logic              excAddrWe,
  output logic [PC_W-1:0]   excAddrVal,
  output logic              swapReq,
  output logic              swapDir,
  output logic              illegalRet,
  output logic              swapErr,
  output logic              shadowActive
);

  seq_ctl_t ctl;
  logic     savedUsr;

  assign savedUsr = !savedExcAddr[0];

  trap_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .faultValid   (faultValid),
    .retValid     (retValid),
    .faultCode    (faultCode),
    .commitPriv   (commitPc[0]),
    .savedUsr     (savedUsr),
    .ctl          (ctl),
    .redirValid   (redirValid),
    .excAddrWe    (excAddrWe),
    .swapReq      (swapReq),
    .swapDir      (swapDir),
    .illegalRet   (illegalRet),
    .swapErr      (swapErr),
    .shadowActive (shadowActive)
  );

  trap_seq_dp #(.PC_W(PC_W), .VEC_OFS(VEC_OFS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .commitPc     (commitPc),
    .faultCode    (faultCode),
    .privBase     (privBase),
    .savedExcAddr (savedExcAddr),
    .newPc        (newPc),
    .nextPc       (nextPc),
    .excAddrVal   (excAddrVal)
  );

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
  import trap_seq_pkg::*;
#(
  parameter int         PC_W    = 32,
  parameter vec_table_t VEC_OFS = defaultVecTable()
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   commitPc,
  input logic [CODE_W-1:0] faultCode,
  input logic              faultValid,
  input logic              retValid,
  input logic [PC_W-1:0]   privBase,
  input logic [PC_W-1:0]   savedExcAddr,
  input logic              redirValid,
  input logic [PC_W-1:0]   newPc,
  input logic [PC_W-1:0]   nextPc,
  input logic              excAddrWe,
  input logic [PC_W-1:0]   excAddrVal,
  input logic              swapReq,
  input logic              swapDir,
  input logic              illegalRet,
  input logic              swapErr,
  input logic              shadowActive
);

  assert_entry_redirect_R2: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> redirValid && nextPc == $past(commitPc) + PC_W'(4)
      && newPc == $past(privBase) + PC_W'(VEC_OFS[$past(faultCode)]));

  assert_no_restart_intr_priv_R3: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && faultCode == CODE_INTR && commitPc[0] |=> !excAddrWe);

  assert_skip_insn_R4: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && (faultCode == CODE_CALL || faultCode == CODE_ARITH)
      |=> excAddrWe && excAddrVal == $past(commitPc) + PC_W'(4));

  assert_swap_in_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && !commitPc[0] && !shadowActive |=> swapReq && swapDir && shadowActive);

  assert_illegal_ret_R6: assert property (@(posedge clk) disable iff (!rstN)
    retValid && !faultValid && !commitPc[0] |=> illegalRet && !redirValid && !swapReq);

  assert_ret_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    retValid && !faultValid && commitPc[0] |=> redirValid && nextPc == $past(savedExcAddr));

  assert_swap_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    swapErr |-> !swapReq && $stable(shadowActive));

  assert_entry_priority_R10: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && retValid |=> !illegalRet);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid && !retValid |=> !redirValid && !excAddrWe && !swapReq && !illegalRet && !swapErr);

endmodule

bind trap_sequencer trap_seq_chk #(.PC_W(PC_W), .VEC_OFS(VEC_OFS)) u_chk (
  .clk(clk), .rstN(rstN), .commitPc(commitPc), .faultCode(faultCode),
  .faultValid(faultValid), .retValid(retValid), .privBase(privBase),
  .savedExcAddr(savedExcAddr), .redirValid(redirValid), .newPc(newPc),
  .nextPc(nextPc), .excAddrWe(excAddrWe), .excAddrVal(excAddrVal),
  .swapReq(swapReq), .swapDir(swapDir), .illegalRet(illegalRet),
  .swapErr(swapErr), .shadowActive(shadowActive)
);

// File: tb/sim_trap_sequencer.sv
module sim_trap_sequencer;

  localparam int PC_W = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] commitPc = '0;
  logic [3:0]      faultCode = '0;
  logic            faultValid = 1'b0;
  logic            retValid = 1'b0;
  logic [PC_W-1:0] privBase = '0;
  logic [PC_W-1:0] savedExcAddr = '0;
  logic            redirValid;
  logic [PC_W-1:0] newPc;
  logic [PC_W-1:0] nextPc;
  logic            excAddrWe;
  logic [PC_W-1:0] excAddrVal;
  logic            swapReq;
  logic            swapDir;
  logic            illegalRet;
  logic            swapErr;
  logic            shadowActive;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit mShadow = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  trap_sequencer #(.PC_W(PC_W)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] stepLfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // Drive at a falling edge, check at the next falling edge.
  task automatic runOp(input bit fv, input bit rv, input logic [3:0] code,
                       input logic [15:0] pc, input logic [15:0] base,
                       input logic [15:0] saved);
    bit eRedir, eWe, eSwap, eDir, eIll, eErr;
    logic [15:0] eNew, eNext, eVal;
    string tRed, tSw;
    eRedir = 0; eWe = 0; eSwap = 0; eDir = 0; eIll = 0; eErr = 0;
    eNew = '0; eNext = '0; eVal = '0;
    tRed = "R11"; tSw = "R11";
    commitPc = pc; faultCode = code; faultValid = fv; retValid = rv;
    privBase = base; savedExcAddr = saved;
    if (fv) begin
      tRed = rv ? "R10" : "R2";
      eRedir = 1;
      eNew = base + 16'(256 * (int'(code) + 1));
      eNext = pc + 16'd4;
      eWe = !(code == 4'd1 && pc[0]);
      eVal = pc + ((code == 4'd2 || code == 4'd3) ? 16'd4 : 16'd0);
      if (!pc[0]) begin
        if (mShadow) begin eErr = 1; tSw = "R9"; end
        else begin eSwap = 1; eDir = 1; mShadow = 1; tSw = "R5"; end
      end
    end else if (rv) begin
      if (!pc[0]) begin
        tRed = "R6"; eIll = 1;
      end else begin
        tRed = "R7"; eRedir = 1; eNew = pc + 16'd4; eNext = saved;
        if (!saved[0]) begin
          if (mShadow) begin eSwap = 1; eDir = 0; mShadow = 0; tSw = "R8"; end
          else begin eErr = 1; tSw = "R9"; end
        end else tSw = "R8";
      end
    end
    @(negedge clk);
    chk({tRed, " redirValid"}, 32'(redirValid), 32'(eRedir));
    chk({tRed, " illegalRet"}, 32'(illegalRet), 32'(eIll));
    if (eRedir) begin
      chk({tRed, " newPc"}, 32'(newPc), 32'(eNew));
      chk({tRed, " nextPc"}, 32'(nextPc), 32'(eNext));
    end
    chk({eWe ? "R3" : tRed, " excAddrWe"}, 32'(excAddrWe), 32'(eWe));
    if (eWe) chk("R4 excAddrVal", 32'(excAddrVal), 32'(eVal));
    chk({tSw, " swapReq"}, 32'(swapReq), 32'(eSwap));
    if (eSwap) chk({tSw, " swapDir"}, 32'(swapDir), 32'(eDir));
    chk({tSw, " swapErr"}, 32'(swapErr), 32'(eErr));
    chk({tSw, " shadowActive"}, 32'(shadowActive), 32'(mShadow));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1 redirValid", 32'(redirValid), 0);
    chk("R1 excAddrWe", 32'(excAddrWe), 0);
    chk("R1 swapReq", 32'(swapReq), 0);
    chk("R1 swapDir", 32'(swapDir), 0);
    chk("R1 illegalRet", 32'(illegalRet), 0);
    chk("R1 swapErr", 32'(swapErr), 0);
    chk("R1 shadowActive", 32'(shadowActive), 0);
    chk("R1 newPc", 32'(newPc), 0);
    chk("R1 nextPc", 32'(nextPc), 0);
    chk("R1 excAddrVal", 32'(excAddrVal), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'(redirValid), 0);
    for (int rep = 0; rep < 4; rep++) begin
      for (int code = 0; code < 16; code++) begin
        for (int priv = 0; priv < 2; priv++) begin
          lfsr = stepLfsr(lfsr);
          runOp(1'b1, 1'b0, 4'(code), {lfsr[15:1], 1'(priv)},
                {lfsr[7:0], lfsr[15:8]}, 16'h0);
          lfsr = stepLfsr(lfsr);
          runOp(1'b0, 1'b1, 4'(code), {lfsr[15:1], 1'(rep >> 1)},
                16'h0, {lfsr[14:0], 1'(rep)});
          if (code % 5 == 0) begin
            lfsr = stepLfsr(lfsr);
            runOp(1'b1, 1'b1, 4'(code), {lfsr[15:1], 1'(priv ^ rep)},
                  lfsr, {lfsr[12:0], 3'b000});
            runOp(1'b0, 1'b0, 4'(code), lfsr, lfsr, lfsr);
          end
        end
      end
    end
    // carry edge: commitPc near the top of the range
    runOp(1'b1, 1'b0, 4'd2, 16'hFFFD, 16'hFF00, 16'h0);
    runOp(1'b1, 1'b0, 4'd1, 16'hFFFF, 16'hF000, 16'h0);
    runOp(1'b0, 1'b1, 4'd0, 16'hFFFF, 16'h0, 16'h1234);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule